// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Stage

This block applies gamma correction to the pixel streams of a three-channel display compositor. One shared table memory holds a red, a green and a blue table of 256 eight-bit entries for every channel. Software fills it through a two-register write port: an address register that carries a start address and an auto-advance flag, and a data register. Each data write stores one entry.

On the pixel side every channel presents a 24-bit RGB word with a valid strobe and its own gamma enable. When the enable is set, each colour component indexes that channel's table for the component, and the three results form the output word. When the enable is clear, the word passes through unchanged, which is the same as an identity table. Both paths take exactly one clock. The memory is split into per-table banks, each with a write port for the register side and a read port for the pixel side. Loading tables therefore never stalls pixel traffic.

Top module: `gamma_lut_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_vld_out` and `pix_out` clear to zero, the write address becomes 0 and auto-advance turns off. A data write that follows reset without an address write stores entry 0.
- R2: A write with `cfg_sel`=0 loads the address register: `cfg_wdata[11:0]` is the address and `cfg_wdata[15]` is the auto-advance flag. A write with `cfg_sel`=1 is a data write and stores `cfg_wdata[7:0]`.
- R3: Entry `idx` of colour `k` (0 red, 1 green, 2 blue) for channel `c` lives at address `c*768 + k*256 + idx`. Within a channel's 24-bit pixel, red is bits [23:16], green [15:8] and blue [7:0]. Channel `c` occupies bits `[24c+23:24c]` of the pixel buses.
- R4: With auto-advance on, each data write stores at the current address and then increments the address by one.
- R5: With auto-advance off, the address does not change, so repeated data writes overwrite the same entry.
- R6: A data write is ignored when the address is 2304 or above. Auto-advance saturates at 2304 after it writes entry 2303, and does not wrap.
- R7: When a channel's enable is set, the output one clock later is the concatenation of its red, green and blue table entries, indexed by the input components.
- R8: When a channel's enable is clear, the output one clock later equals the input pixel.
- R9: `pix_vld_out[c]` equals `pix_vld_in[c]` delayed by one clock.
- R10: Data writes and lookups may occur in the same cycle without a stall. A lookup in the cycle that writes its entry returns the previous contents. Later lookups return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 the data register |
| cfg_wdata | input | 16 | Register write value |
| gamma_en | input | 3 | Per-channel lookup enable |
| pix_vld_in | input | 3 | Per-channel input valid |
| pix_in | input | 72 | Packed input pixels, 24 bits per channel |
| pix_vld_out | output | 3 | Per-channel output valid |
| pix_out | output | 72 | Packed output pixels, 24 bits per channel |

## Verification
The bench goes after the end of the table memory. It writes entry 2303 with auto-advance on and then writes again. A design that wraps the address would corrupt entry 0 of channel 0's red table, and a design that stops one entry early would leave entry 2303 stale. Writes to addresses past the end are followed by lookups of the low entries, so any aliasing shows up in the outputs. A mid-run reset followed by data writes without an address write exposes a register that forgets to clear the address or the flag. Random traffic mixes writes into tables that are being looked up in the same cycle, with enables toggling per channel. A design that forwards the new write data, or that gives the bypass path a different latency, miscompares there.

// File: rtl/gamma_lut_pkg.sv
// Shared constants for the gamma lookup stage.
// Assumes the colour order red, green, blue both in memory and in the pixel word.
package gamma_lut_pkg;
    localparam int COLORS = 3;
    typedef enum logic [1:0] {
        CLR_RED = 2'd0,
        CLR_GRN = 2'd1,
        CLR_BLU = 2'd2
    } color_e;
endpackage

// File: rtl/gamma_loader.sv
// Register-port front end: holds the write address and the auto-advance flag,
// and turns data writes into memory write strobes.
// Assumes ADDR_W bits can hold DEPTH and that the flag bit sits above the address field.
module gamma_loader #(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int REG_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              inc_on,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    logic in_range;
    logic unused_bits;

    // Address range test and write strobe to the memory banks.
    always_comb begin
        in_range = (ptr < LIMIT);
        wr_en    = cfg_we && cfg_sel && in_range;
        wr_addr  = ptr;
        wr_data  = cfg_wdata[DATA_W-1:0];
    end

    assign unused_bits = ^cfg_wdata[REG_W-2:ADDR_W];

    // Address register update: load, saturating advance, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            inc_on <= 1'b0;
        end else if (cfg_we && !cfg_sel) begin
            ptr    <= cfg_wdata[ADDR_W-1:0];
            inc_on <= cfg_wdata[REG_W-1];
        end else if (wr_en && inc_on) begin
            ptr    <= ptr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/gamma_bank.sv
// One table of ENTRIES words: a write port for loading and a synchronous
// read port for lookup. A read in the same cycle as a write to the same word
// returns the old word. Contents are not reset.
module gamma_bank #(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [ENTRIES];

    // Load port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Lookup port, registered.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/gamma_channel.sv
// One compositor channel: three table banks plus a registered bypass path,
// so both lookup and pass-through take one clock.
// Assumes banks are numbered channel*COLORS + colour in the shared address space.
module gamma_channel
    import gamma_lut_pkg::*;
#(
    parameter int CH_ID   = 0,
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PIX_W  = COLORS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              en,
    input  logic              vld,
    input  logic [PIX_W-1:0]  pix,
    output logic              vld_out,
    output logic [PIX_W-1:0]  pix_out
);
    logic [PIX_W-1:0] lut_word;
    logic [PIX_W-1:0] pix_q;
    logic             en_q;
    logic             vld_q;

    for (genvar k = 0; k < COLORS; k++) begin : g_tbl
        localparam int SLICE = (COLORS - 1 - k) * DATA_W;
        localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(CH_ID * COLORS + k);
        logic bank_we;
        logic [IDX_W-1:0] rd_idx;

        assign bank_we = wr_en && (wr_bank == MY_BANK);
        assign rd_idx  = pix[SLICE +: IDX_W];

        gamma_bank #(
            .ENTRIES (ENTRIES),
            .DATA_W  (DATA_W)
        ) u_bank (
            .clk     (clk),
            .wr_en   (bank_we),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_idx  (rd_idx),
            .rd_data (lut_word[SLICE +: DATA_W])
        );
    end

    // Bypass and control pipeline, matched to the bank read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            en_q  <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= vld;
            en_q  <= en;
            pix_q <= pix;
        end
    end

    // Output select between table result and delayed input.
    always_comb begin
        vld_out = vld_q;
        pix_out = en_q ? lut_word : pix_q;
    end
endmodule

// File: rtl/gamma_lut_top.sv
// Gamma lookup stage for NUM_CH compositor channels with a shared,
// register-loaded table space of NUM_CH * 3 * ENTRIES entries.
// Assumes ENTRIES is a power of two, so an address splits into bank and index.
module gamma_lut_top
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 8,
    parameter int REG_W   = 16,
    localparam int PIX_W  = COLORS * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [REG_W-1:0]         cfg_wdata,
    input  logic [NUM_CH-1:0]        gamma_en,
    input  logic [NUM_CH-1:0]        pix_vld_in,
    input  logic [NUM_CH*PIX_W-1:0]  pix_in,
    output logic [NUM_CH-1:0]        pix_vld_out,
    output logic [NUM_CH*PIX_W-1:0]  pix_out
);
    localparam int DEPTH  = NUM_CH * COLORS * ENTRIES;
    localparam int ADDR_W = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int BANK_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] ld_ptr;
    logic              ld_inc;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BANK_W-1:0] wr_bank;
    logic [IDX_W-1:0]  wr_idx;

    gamma_loader #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ptr       (ld_ptr),
        .inc_on    (ld_inc),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // Split the flat address into table number and entry index.
    assign wr_bank = wr_addr[ADDR_W-1:IDX_W];
    assign wr_idx  = wr_addr[IDX_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gamma_channel #(
            .CH_ID   (c),
            .ENTRIES (ENTRIES),
            .DATA_W  (DATA_W),
            .BANK_W  (BANK_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_bank (wr_bank),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .en      (gamma_en[c]),
            .vld     (pix_vld_in[c]),
            .pix     (pix_in[c*PIX_W +: PIX_W]),
            .vld_out (pix_vld_out[c]),
            .pix_out (pix_out[c*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/gamma_lut_chk.sv
// Property checker for gamma_lut_top, attached by bind below.
module gamma_lut_chk #(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 24,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2304
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    cfg_sel,
    input logic [REG_W-1:0]        cfg_wdata,
    input logic [NUM_CH-1:0]       gamma_en,
    input logic [NUM_CH-1:0]       pix_vld_in,
    input logic [NUM_CH*PIX_W-1:0] pix_in,
    input logic [NUM_CH-1:0]       pix_vld_out,
    input logic [NUM_CH*PIX_W-1:0] pix_out,
    input logic [ADDR_W-1:0]       ld_ptr,
    input logic                    ld_inc
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pix_vld_out == '0 && pix_out == '0 && ld_ptr == '0 && !ld_inc));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (ld_ptr == $past(cfg_wdata[ADDR_W-1:0]) && ld_inc == $past(cfg_wdata[REG_W-1])));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && ld_inc && ld_ptr < LIMIT) |=> (ld_ptr == $past(ld_ptr) + ADDR_W'(1)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && !ld_inc) |=> $stable(ld_ptr));

    // R6
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && ld_ptr >= LIMIT) |=> $stable(ld_ptr));

    // R9
    vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pix_vld_out == $past(pix_vld_in)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bp
        // R8
        bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pix_vld_in[c]) && !$past(gamma_en[c]))
            |-> (pix_out[c*PIX_W +: PIX_W] == $past(pix_in[c*PIX_W +: PIX_W])));
    end
endmodule

bind gamma_lut_top gamma_lut_chk #(
    .NUM_CH (NUM_CH),
    .PIX_W  (PIX_W),
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .gamma_en    (gamma_en),
    .pix_vld_in  (pix_vld_in),
    .pix_in      (pix_in),
    .pix_vld_out (pix_vld_out),
    .pix_out     (pix_out),
    .ld_ptr      (ld_ptr),
    .ld_inc      (ld_inc)
);

// File: tb/sim_gamma_lut_top.sv
`timescale 1ns/1ps
module sim_gamma_lut_top;
    localparam int NCH   = 3;
    localparam int ENT   = 256;
    localparam int DEPTH = NCH * 3 * ENT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  gamma_en = '0;
    logic [2:0]  pix_vld_in = '0;
    logic [71:0] pix_in = '0;
    logic [2:0]  pix_vld_out;
    logic [71:0] pix_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [DEPTH];
    int  mptr = 0;
    bit  minc = 1'b0;

    always #2.5 clk = ~clk;

    gamma_lut_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .gamma_en(gamma_en), .pix_vld_in(pix_vld_in),
        .pix_in(pix_in), .pix_vld_out(pix_vld_out), .pix_out(pix_out)
    );

    // Expected output word of one channel from the table model (R3, R7, R8).
    function automatic logic [23:0] exp_pix(int c, logic [23:0] px, bit en);
        logic [23:0] r;
        if (!en) return px;
        for (int k = 0; k < 3; k++)
            r[(2-k)*8 +: 8] = model[c*768 + k*256 + int'(px[(2-k)*8 +: 8])];
        return r;
    endfunction

    task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus with checks one clock later; starts and ends at a negedge.
    task automatic cycle(bit wr, bit sel, logic [15:0] wd, logic [71:0] px,
                         logic [2:0] v, logic [2:0] e, string tag);
        logic [23:0] exp [NCH];
        cfg_we = wr; cfg_sel = sel; cfg_wdata = wd;
        pix_in = px; pix_vld_in = v; gamma_en = e;
        for (int c = 0; c < NCH; c++) exp[c] = exp_pix(c, px[c*24 +: 24], e[c]);
        if (wr && !sel) begin
            mptr = int'(wd[11:0]); minc = wd[15];
        end else if (wr && sel && mptr < DEPTH) begin
            model[mptr] = wd[7:0];
            if (minc) mptr++;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; pix_vld_in = '0;
        check("R9 valid", {21'd0, pix_vld_out}, {21'd0, v});
        for (int c = 0; c < NCH; c++)
            if (v[c]) check(e[c] ? tag : "R8 bypass", pix_out[c*24 +: 24], exp[c]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; pix_vld_in = '0; gamma_en = '0; pix_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mptr = 0; minc = 1'b0;
    endtask

    function automatic logic [71:0] rnd_px();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        do_reset();
        // R1: outputs clear after reset
        check("R1 vld", {21'd0, pix_vld_out}, 24'd0);
        check("R1 pix", pix_out[23:0], 24'd0);

        // R2 R4: fill every table through auto-advance from address 0
        cycle(1, 0, 16'h8000, '0, '0, '0, "R2");
        for (int i = 0; i < DEPTH; i++)
            cycle(1, 1, 16'($urandom()), '0, '0, '0, "R4");

        // R3 R7 R8: random lookups, enables and valids
        for (int i = 0; i < 300; i++)
            cycle(0, 0, '0, rnd_px(), 3'($urandom()), 3'($urandom()), "R7 R3 lookup");

        // R5: no auto-advance, repeated writes land on one entry (ch1 green 0x40)
        cycle(1, 0, 16'(768 + 256 + 64), '0, '0, '0, "R2");
        cycle(1, 1, 16'h0011, '0, '0, '0, "R5");
        cycle(1, 1, 16'h00C3, '0, '0, '0, "R5");
        cycle(0, 0, '0, {24'h0, 24'h004041, 24'h0}, 3'b010, 3'b010, "R5 hold");

        // R6: last entry written, then saturation and out-of-range writes ignored
        cycle(1, 0, 16'h8000 | 16'(DEPTH - 1), '0, '0, '0, "R2");
        cycle(1, 1, 16'h00E7, '0, '0, '0, "R6");
        cycle(1, 1, 16'h0099, '0, '0, '0, "R6");
        cycle(1, 0, 16'h8000 | 16'(DEPTH + 5), '0, '0, '0, "R2");
        cycle(1, 1, 16'h0077, '0, '0, '0, "R6");
        cycle(1, 0, 16'h0FFF, '0, '0, '0, "R2");
        cycle(1, 1, 16'h0066, '0, '0, '0, "R6");
        cycle(0, 0, '0, {24'h0000FF, 24'h0, 24'h000505}, 3'b101, 3'b101, "R6 bound");
        cycle(0, 0, '0, {24'h0, 24'h0, 24'hFFFFFF}, 3'b001, 3'b001, "R6 bound");

        // R10: writes mixed with lookups, including same-cycle hits
        for (int i = 0; i < 400; i++) begin
            bit wr  = ($urandom() % 3) != 0;
            bit sel = ($urandom() % 8) != 0;
            logic [15:0] wd = sel ? 16'($urandom()) :
                              ((($urandom() % 2) != 0 ? 16'h8000 : 16'h0) |
                               16'($urandom() % (DEPTH + 20)));
            cycle(wr, sel, wd, rnd_px(), 3'($urandom()), 3'($urandom()), "R10 R7 mixed");
        end

        // R1: address and flag cleared by reset, tables kept
        do_reset();
        cycle(1, 1, 16'h005A, '0, '0, '0, "R1");
        cycle(1, 1, 16'h00A5, '0, '0, '0, "R1");
        cycle(0, 0, '0, {48'h0, 24'h000101}, 3'b001, 3'b001, "R1 addr reset");
        cycle(0, 0, '0, {48'h0, 24'h010000}, 3'b001, 3'b001, "R1 addr reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule